// File: doc/BRIEF.md
# Multiplexed Asynchronous Parallel Memory Port

This block joins an internal requester that works in 32-bit words to asynchronous external memory. The memory side has 16 pins that carry both address and data at different times. Each external transfer starts with an optional address latch cycle that pulses an address-latch-enable output. A read or write strobe of programmable length follows. A requester, such as a DMA engine, raises `req_valid` with a start address, a direction and, for writes, a 32-bit word. The port then makes the external transfers for that word. It raises `req_ack` for one cycle when the whole word is done.

Two bus modes are supported. In byte mode (`cfg_byte_mode` = 1) the external address is 24 bits and a word takes four 8-bit transfers. The latch cycle carries address bits 23:8. During the strobe, pins 15:8 carry address bits 7:0 and pins 7:0 carry data. In halfword mode (`cfg_byte_mode` = 0) the external address is 16 bits and a word takes two 16-bit transfers. Every transfer is latched, because all 16 pins carry data during the strobe. In byte mode the latch cycle is skipped while consecutive transfers stay in the 256-address page that was last latched.

The controller has five states. IDLE waits for a request. LATCH lasts one cycle and drives the address with the enable pulse. STROBE holds the read or write strobe low for the programmed width. GAP is a one-cycle pause between transfers of the same word. DONE acknowledges the word. The transitions are:
- IDLE to LATCH on a request that needs a latch.
- IDLE to STROBE on a byte-mode request that hits the latched page.
- LATCH to STROBE always.
- STROBE to GAP when the strobe ends and transfers remain.
- STROBE to DONE when the strobe ends after the last transfer.
- GAP to LATCH or to STROBE, by the same latch rule as from IDLE.
- DONE to IDLE always.

Top module: `mpx_mem_port`

## Requirements
- R1: During and right after reset, `rd_n` and `wr_n` are 1, `ale` is 0, `bus_oe` is all zeros and `req_ack` is 0.
- R2: Each read or write strobe stays low for exactly `cfg_strobe` cycles when that value is 2 to 31. A value of 0 or 1 gives 2 cycles. The value is taken when the request is accepted.
- R3: In byte mode, the latch cycle drives address bits 23:8 on pins 15:0. During a strobe, pins 15:8 carry address bits 7:0 and pins 7:0 carry the data byte.
- R4: In halfword mode, each of the two transfers of a word is preceded by a latch cycle that drives address bits 15:0. The transfers use addresses A and A+1, wrapping in 16 bits, and their data uses all 16 pins.
- R5: Reads are packed little-endian. Transfer i of a word, at address A+i, fills byte i (byte mode) or halfword i (halfword mode) of `rsp_rdata`.
- R6: Writes are unpacked the same way. Transfer i drives byte i or halfword i of the accepted word, and the data pins stay constant for the whole strobe.
- R7: In byte mode, a latch cycle is issued only when address bits 23:8 differ from the page last latched. The first byte-mode transfer after reset, or after any halfword-mode transfer, is always latched. A page crossing inside a word re-latches before the crossing transfer.
- R8: During a read strobe, the port releases the pins that carry data (`bus_oe` bits 7:0 in byte mode, all 16 bits in halfword mode). It samples `bus_in` only on the last cycle of the strobe.
- R9: `req_ack` is a one-cycle pulse given once per completed 32-bit word, never per transfer. `rsp_rdata` holds the packed read word while `req_ack` is high.
- R10: `rd_n` and `wr_n` are never low together. `ale` is never high while a strobe is low. Two strobes are always separated by at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_byte_mode | input | 1 | 1 = 8-bit data with 24-bit address, 0 = 16-bit data with 16-bit address |
| cfg_strobe | input | 5 | Strobe width in cycles (2 to 31) |
| req_valid | input | 1 | Word request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | External address of the first transfer |
| req_wdata | input | 32 | Word to write |
| req_ack | output | 1 | One-cycle pulse when the word completes |
| rsp_rdata | output | 32 | Packed read word, valid while req_ack is high |
| bus_out | output | 16 | Value driven on the shared pins |
| bus_oe | output | 16 | Per-pin output enable |
| bus_in | input | 16 | Value read from the shared pins |
| ale | output | 1 | Address-latch-enable pulse |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The assertions assume the requester holds `req_valid` and the request fields steady until `req_ack`, and drops `req_valid` in the cycle after `req_ack`. They also assume `rst_n` is applied from time zero. The bench meets these by driving each request on a falling edge and waiting for the acknowledge before it lowers `req_valid`. The bench's memory model drives a garbage value on `bus_in` on every strobe cycle except the last. This makes a read that samples on any other cycle visible.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LATCH  = 3'd1,
        ST_STROBE = 3'd2,
        ST_GAP    = 3'd3,
        ST_DONE   = 3'd4
    } mpx_state_t;
endpackage

// File: rtl/mpx_strobe_timer.sv
module mpx_strobe_timer #(
    parameter int STRB_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [STRB_W-1:0] width,
    output logic              last
);
    logic [STRB_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (run && !last)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

    assign last = run && (cnt == width - 1'b1);
endmodule

// File: rtl/mpx_page_track.sv
module mpx_page_track #(
    parameter int PAGE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store,
    input  logic              forget,
    input  logic [PAGE_W-1:0] page_in,
    input  logic [PAGE_W-1:0] page_q,
    output logic              hit
);
    logic              held_vld;
    logic [PAGE_W-1:0] held_page;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_vld  <= 1'b0;
            held_page <= '0;
        end else if (store) begin
            held_vld  <= 1'b1;
            held_page <= page_in;
        end else if (forget) begin
            held_vld  <= 1'b0;
        end
    end

    assign hit = held_vld && (held_page == page_q);
endmodule

// File: rtl/mpx_packer.sv
module mpx_packer #(
    parameter int PIN_W  = 16,
    parameter int WORD_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              byte_mode,
    input  logic [IDX_W-1:0]  idx,
    input  logic              capture,
    input  logic [PIN_W-1:0]  pin_data,
    output logic [PIN_W-1:0]  tx_data,
    output logic [WORD_W-1:0] rx_word
);
    localparam int BYTES = WORD_W / 8;
    localparam int HALVES = WORD_W / PIN_W;

    logic [WORD_W-1:0] wbuf;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wbuf <= '0;
        else if (load)
            wbuf <= load_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word <= '0;
        end else if (capture) begin
            for (int b = 0; b < BYTES; b++) begin
                if (byte_mode && (idx == IDX_W'(b)))
                    rx_word[b*8 +: 8] <= pin_data[7:0];
            end
            for (int h = 0; h < HALVES; h++) begin
                if (!byte_mode && (idx == IDX_W'(h)))
                    rx_word[h*PIN_W +: PIN_W] <= pin_data;
            end
        end
    end

    always_comb begin
        tx_data = '0;
        for (int b = 0; b < BYTES; b++) begin
            if (byte_mode && (idx == IDX_W'(b)))
                tx_data[7:0] = wbuf[b*8 +: 8];
        end
        for (int h = 0; h < HALVES; h++) begin
            if (!byte_mode && (idx == IDX_W'(h)))
                tx_data = wbuf[h*PIN_W +: PIN_W];
        end
    end
endmodule

// File: rtl/mpx_mem_port.sv
module mpx_mem_port
    import mpx_pkg::*;
#(
    parameter int PIN_W  = 16,
    parameter int WORD_W = 32,
    parameter int STRB_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_byte_mode,
    input  logic [STRB_W-1:0]   cfg_strobe,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [PIN_W+7:0]    req_addr,
    input  logic [WORD_W-1:0]   req_wdata,
    output logic                req_ack,
    output logic [WORD_W-1:0]   rsp_rdata,
    output logic [PIN_W-1:0]    bus_out,
    output logic [PIN_W-1:0]    bus_oe,
    input  logic [PIN_W-1:0]    bus_in,
    output logic                ale,
    output logic                rd_n,
    output logic                wr_n
);
    localparam int ADDR_W = PIN_W + 8;
    localparam int PAGE_W = ADDR_W - 8;
    localparam int IDX_W  = $clog2(WORD_W / 8);
    localparam logic [STRB_W-1:0] MIN_STRB = STRB_W'(2);

    mpx_state_t state, state_nx;

    logic [ADDR_W-1:0] cur_addr;
    logic              wr_q;
    logic              byte_q;
    logic [STRB_W-1:0] width_q;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;
    logic              strobe_last;
    logic              page_hit;
    logic [PAGE_W-1:0] page_q;
    logic              need_latch;
    logic              accept;
    logic [PIN_W-1:0]  tx_data;
    logic              in_strobe;

    assign accept    = (state == ST_IDLE) && req_valid;
    assign in_strobe = (state == ST_STROBE);
    assign last_idx  = byte_q ? IDX_W'((WORD_W / 8) - 1) : IDX_W'((WORD_W / PIN_W) - 1);

    // Page under test: request address when idle, running address otherwise.
    assign page_q = (state == ST_IDLE) ? req_addr[ADDR_W-1:8] : cur_addr[ADDR_W-1:8];

    always_comb begin
        if (state == ST_IDLE)
            need_latch = !cfg_byte_mode || !page_hit;
        else
            need_latch = !byte_q || !page_hit;
    end

    mpx_page_track #(.PAGE_W(PAGE_W)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .store   ((state == ST_LATCH) && byte_q),
        .forget  ((state == ST_LATCH) && !byte_q),
        .page_in (cur_addr[ADDR_W-1:8]),
        .page_q  (page_q),
        .hit     (page_hit)
    );

    mpx_strobe_timer #(.STRB_W(STRB_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_strobe),
        .width (width_q),
        .last  (strobe_last)
    );

    mpx_packer #(.PIN_W(PIN_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word (req_wdata),
        .byte_mode (byte_q),
        .idx       (idx),
        .capture   (strobe_last && !wr_q),
        .pin_data  (bus_in),
        .tx_data   (tx_data),
        .rx_word   (rsp_rdata)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = need_latch ? ST_LATCH : ST_STROBE;
            ST_LATCH:  state_nx = ST_STROBE;
            ST_STROBE: if (strobe_last) state_nx = (idx == last_idx) ? ST_DONE : ST_GAP;
            ST_GAP:    state_nx = need_latch ? ST_LATCH : ST_STROBE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Transfer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            wr_q     <= 1'b0;
            byte_q   <= 1'b0;
            width_q  <= MIN_STRB;
            idx      <= '0;
        end else if (accept) begin
            cur_addr <= cfg_byte_mode ? req_addr : {8'h00, req_addr[PIN_W-1:0]};
            wr_q     <= req_write;
            byte_q   <= cfg_byte_mode;
            width_q  <= (cfg_strobe < MIN_STRB) ? MIN_STRB : cfg_strobe;
            idx      <= '0;
        end else if (strobe_last) begin
            idx <= idx + 1'b1;
            if (byte_q)
                cur_addr <= cur_addr + 1'b1;
            else
                cur_addr <= {8'h00, cur_addr[PIN_W-1:0] + 1'b1};
        end
    end

    // Outputs
    always_comb begin
        ale     = 1'b0;
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        req_ack = 1'b0;
        bus_out = '0;
        bus_oe  = '0;
        unique case (state)
            ST_LATCH: begin
                ale     = 1'b1;
                bus_out = byte_q ? cur_addr[ADDR_W-1:8] : cur_addr[PIN_W-1:0];
                bus_oe  = '1;
            end
            ST_STROBE: begin
                rd_n    = wr_q;
                wr_n    = !wr_q;
                bus_out = byte_q ? {cur_addr[7:0], tx_data[7:0]} : tx_data;
                if (wr_q)
                    bus_oe = '1;
                else if (byte_q)
                    bus_oe = {{(PIN_W-8){1'b1}}, 8'h00};
                else
                    bus_oe = '0;
            end
            ST_DONE: req_ack = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mpx_port_chk.sv
module mpx_port_chk #(
    parameter int PIN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_n,
    input logic             wr_n,
    input logic             ale,
    input logic             req_ack,
    input logic [PIN_W-1:0] bus_out,
    input logic [PIN_W-1:0] bus_oe
);
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_ale_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

    assert_rd_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (bus_oe[7:0] == 8'h00));

    assert_rd_min_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |=> !rd_n);

    assert_wr_min_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n) |=> !wr_n);

    assert_strobe_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> (rd_n && wr_n));

    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    assert_wr_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> $stable(bus_out));
endmodule

bind mpx_mem_port mpx_port_chk #(.PIN_W(PIN_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .ale     (ale),
    .req_ack (req_ack),
    .bus_out (bus_out),
    .bus_oe  (bus_oe)
);

// File: tb/sim_mpx_mem_port.sv
`timescale 1ns/1ps
module sim_mpx_mem_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_byte_mode = 1'b1;
    logic [4:0]  cfg_strobe = 5'd3;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ack;
    logic [31:0] rsp_rdata;
    logic [15:0] bus_out, bus_oe;
    logic [15:0] bus_in = 16'hDEAD;
    logic        ale, rd_n, wr_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mpx_mem_port u0 (.*);

    function automatic logic [7:0] mem8(input logic [23:0] a);
        return a[7:0] + (a[15:8] * 8'd3) + a[23:16] + 8'h11;
    endfunction

    function automatic logic [15:0] mem16(input logic [15:0] a);
        return {a[7:0] ^ 8'h3C, a[15:8] + 8'h21};
    endfunction

    // Bus monitor and memory model, all on falling edges
    logic [15:0] lat_q = '0;
    int ale_cnt = 0, ack_cnt = 0, rd_run = 0, wr_run = 0;
    int last_rd_len = 0, last_wr_len = 0, bad_oe = 0, overlap = 0;
    logic [23:0] wlog_a [0:7];
    logic [15:0] wlog_d [0:7];
    int wcnt = 0;
    logic prev_wr_n = 1'b1;

    always @(negedge clk) begin
        if (ale) begin
            ale_cnt++;
            lat_q = bus_out;
        end
        if (req_ack) ack_cnt++;
        if ((!rd_n && !wr_n) || (ale && (!rd_n || !wr_n))) overlap++;
        if (!wr_n && prev_wr_n && wcnt < 8) begin
            wlog_a[wcnt] = cfg_byte_mode ? {lat_q, bus_out[15:8]} : {8'h00, lat_q};
            wlog_d[wcnt] = cfg_byte_mode ? {8'h00, bus_out[7:0]} : bus_out;
            wcnt++;
        end
        prev_wr_n = wr_n;
        if (!wr_n) wr_run++;
        else if (wr_run > 0) begin last_wr_len = wr_run; wr_run = 0; end
        if (!rd_n) begin
            rd_run++;
            if (cfg_byte_mode ? (bus_oe[7:0] != 8'h00) : (bus_oe != 16'h0000)) bad_oe++;
            if (rd_run == ((cfg_strobe < 5'd2) ? 2 : int'(cfg_strobe)))
                bus_in = cfg_byte_mode ? {8'hEE, mem8({lat_q, bus_out[15:8]})} : mem16(lat_q);
            else
                bus_in = 16'hBAD0 + 16'(rd_run);
        end else begin
            if (rd_run > 0) last_rd_len = rd_run;
            rd_run = 0;
            bus_in = 16'hDEAD;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        ale_cnt = 0; ack_cnt = 0; wcnt = 0; bad_oe = 0;
        last_rd_len = 0; last_wr_len = 0;
    endtask

    task automatic do_req(input logic wr, input logic [23:0] a, input logic [31:0] wd,
                          output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        for (int t = 0; t < 500; t++) begin
            @(negedge clk);
            if (req_ack) break;
        end
        rd = rsp_rdata;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 rd_n", {31'd0, rd_n}, 32'd1);
        check("R1 wr_n", {31'd0, wr_n}, 32'd1);
        check("R1 ale", {31'd0, ale}, 32'd0);
        check("R1 bus_oe", {16'd0, bus_oe}, 32'd0);
        check("R1 ack", {31'd0, req_ack}, 32'd0);
    endtask

    task automatic t_byte_read(input logic [23:0] a, input logic [4:0] w, input int exp_ale);
        logic [31:0] rd;
        clear_mon(); cfg_byte_mode = 1'b1; cfg_strobe = w;
        do_req(1'b0, a, 32'h0, rd);
        check("R5 R3 R8 byte read word", rd,
              {mem8(a + 24'd3), mem8(a + 24'd2), mem8(a + 24'd1), mem8(a)});
        check("R7 latch count", ale_cnt, exp_ale);
        check("R2 read strobe width", last_rd_len, (w < 5'd2) ? 2 : int'(w));
        check("R9 one ack per word", ack_cnt, 1);
        check("R8 data pins released", bad_oe, 0);
    endtask

    task automatic t_half_read(input logic [15:0] a, input logic [4:0] w);
        logic [31:0] rd;
        clear_mon(); cfg_byte_mode = 1'b0; cfg_strobe = w;
        do_req(1'b0, {8'h77, a}, 32'h0, rd);
        check("R5 R4 half read word", rd, {mem16(a + 16'd1), mem16(a)});
        check("R4 latch per transfer", ale_cnt, 2);
        check("R2 read strobe width", last_rd_len, int'(w));
        check("R8 all pins released", bad_oe, 0);
        check("R9 one ack per word", ack_cnt, 1);
    endtask

    task automatic t_byte_write(input logic [23:0] a, input logic [31:0] wd, input logic [4:0] w);
        logic [31:0] rd;
        clear_mon(); cfg_byte_mode = 1'b1; cfg_strobe = w;
        do_req(1'b1, a, wd, rd);
        check("R6 byte write transfers", wcnt, 4);
        for (int i = 0; i < 4; i++) begin
            check("R3 R6 byte write addr", {8'h0, wlog_a[i]}, {8'h0, a + 24'(i)});
            check("R6 byte write data", {16'h0, wlog_d[i]}, {24'h0, wd[i*8 +: 8]});
        end
        check("R2 write strobe width", last_wr_len, int'(w));
        check("R7 latch after halfword use", ale_cnt, 1);
        check("R9 one ack per word", ack_cnt, 1);
    endtask

    task automatic t_half_write(input logic [15:0] a, input logic [31:0] wd);
        logic [31:0] rd;
        clear_mon(); cfg_byte_mode = 1'b0; cfg_strobe = 5'd4;
        do_req(1'b1, {8'h00, a}, wd, rd);
        check("R6 half write transfers", wcnt, 2);
        for (int i = 0; i < 2; i++) begin
            check("R4 half write addr", {8'h0, wlog_a[i]}, {16'h0, 16'(a + 16'(i))});
            check("R6 half write data", {16'h0, wlog_d[i]}, {16'h0, wd[i*16 +: 16]});
        end
        check("R4 latch per transfer", ale_cnt, 2);
    endtask

    initial begin
        bit timed_out;
        timed_out = 1'b0;
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                rst_n = 1'b1;
                t_reset();
                t_byte_read(24'h123400, 5'd3, 1);   // first access latches
                t_byte_read(24'h123404, 5'd7, 0);   // same page, no latch (R7)
                t_byte_read(24'h1234FE, 5'd2, 1);   // page crossing mid-word (R7)
                t_half_read(16'h0456, 5'd5);
                t_half_read(16'hFFFF, 5'd2);        // 16-bit wrap (R4)
                t_byte_write(24'h123510, 32'hA1B2C3D4, 5'd31);
                t_half_write(16'h0FFF, 32'h5566_7788);
                t_byte_read(24'h123520, 5'd0, 1);   // width 0 -> 2, relatch after halfword (R2 R7)
                t_byte_read(24'h123524, 5'd1, 0);   // width 1 -> 2
                check("R10 no strobe overlap", overlap, 0);
            end
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule